// File: doc/BRIEF.md
# Serial Management Slave for a Line PHY

This block is the management-side slave inside a PHY. It runs entirely on the management clock, which the external station sources. That clock may be gated off whenever the bus is idle. The shared data line is split into three signals: an input sample, an output value and an output enable. The pad and its pull-up are outside the block. Every bit of the line is sampled on the rising clock edge. The block finds the start of each frame and decodes the operation, the device address and the register address. It then either captures sixteen bits of write data into a local file of 32 sixteen-bit registers, or drives the turnaround and the read data back onto the line.

The device address is a three-bit strap value. It is captured while reset is low and kept for as long as reset stays high. Frames addressed to other devices are followed through to their last bit, but the block does not drive the line and does not change any register for them. The bit rate and framing are fixed by the station, so the serial data path has no valid/ready handshake and no back-pressure. A bit is consumed or produced on every rising edge of the management clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Bits are sampled on the rising clock edge. A frame opens with a 0 followed by a 1, and the 0 must follow at least one high idle bit. Then come a 2-bit opcode (10 read, 01 write), a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent MSB first.
- R2: A frame is served only when device address bits [4:3] are 00 and bits [2:0] equal the latched strap value.
- R3: The strap value is captured while reset is low. Changes on the strap pins after reset is released have no effect.
- R4: The output enable is low during reset. The first rising clock edge after reset is released is ignored for framing.
- R5: On a served read, the line is left undriven for the first turnaround bit. The block drives 0 for the second turnaround bit.
- R6: On a served read, the 16 data bits are driven MSB first, each one stable across the rising edge that samples it. The output enable drops right after the last data bit.
- R7: On a served write, the 16 data bits are written to the addressed register when the last data bit is sampled. The block never drives the line during a write frame.
- R8: A frame for another device never drives the line and never changes a register.
- R9: An opcode of 00 or 11 sends the block back to searching for a start pattern, with its output enable low. A later valid frame is served normally.
- R10: The 32 registers reset to 0000 and are independent: writing one leaves all the others unchanged.
- R11: The clock may stop for any length of time between frames without losing register contents or framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station; may stop while idle |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| strap_i | input | 3 | Device address strap, captured while reset is low |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value to drive onto the data line |
| mdio_oe | output | 1 | Output enable for the data line pad |

## Verification
The bench uses the default parameters: 32 registers of 16 bits, a 5-bit device address and a 3-bit strap. It latches strap value 5, so both the lowest and highest register addresses and a strap with mixed bits are covered. It also exercises a device address that matches in its low three bits but has an upper bit set. Around these accesses it covers a frame that begins on the very first clock after reset, strap pins that move after reset, both invalid opcodes, and a clock that stops between frames.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OPC,
    ST_ADDR,
    ST_TURN,
    ST_DATA
  } mdio_st_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && waddr == AW'(g))    q <= wdata;
    end
    assign mem[g] = q;
  end

  assign rdata = mem[raddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R7
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 5,
  parameter int PAW = 5,
  parameter int SW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  strap,
  input  logic           mdio_i,
  output logic [RAW-1:0] rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           mdio_o,
  output logic           mdio_oe
);
  localparam int AW_TOT  = PAW + RAW;
  localparam int CNT_MAX = (DW > AW_TOT) ? DW : AW_TOT;
  localparam int CW      = $clog2(CNT_MAX);
  localparam logic [CW-1:0] LAST_ADDR = CW'(AW_TOT - 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW - 1);

  mdio_st_e       state;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  sh;
  logic           armed, seen_one, is_rd, match_q;
  logic [RAW-1:0] reg_q;

  logic [AW_TOT-1:0] addr_full;
  logic [PAW-1:0]    phy_w;
  logic              match_w;

  assign addr_full = {sh[AW_TOT-2:0], mdio_i};
  assign phy_w     = addr_full[AW_TOT-1:RAW];
  assign match_w   = (phy_w[PAW-1:SW] == '0) && (phy_w[SW-1:0] == strap);
  assign rd_addr   = addr_full[RAW-1:0];

  assign wr_en   = (state == ST_DATA) && (cnt == LAST_DATA) && !is_rd && match_q;
  assign wr_addr = reg_q;
  assign wr_data = {sh[DW-2:0], mdio_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      sh       <= '0;
      armed    <= 1'b0;
      seen_one <= 1'b0;
      is_rd    <= 1'b0;
      match_q  <= 1'b0;
      reg_q    <= '0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
    end else begin
      case (state)
        ST_HUNT: begin
          if (mdio_i) seen_one <= 1'b1;
          else if (seen_one) begin
            state    <= ST_START;
            seen_one <= 1'b0;
          end
        end
        ST_START: begin
          cnt   <= '0;
          state <= mdio_i ? ST_OPC : ST_HUNT;
        end
        ST_OPC: begin
          sh  <= {sh[DW-2:0], mdio_i};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) begin
            cnt <= '0;
            case ({sh[0], mdio_i})
              OPC_RD:  begin is_rd <= 1'b1; state <= ST_ADDR; end
              OPC_WR:  begin is_rd <= 1'b0; state <= ST_ADDR; end
              default: state <= ST_HUNT;
            endcase
          end
        end
        ST_ADDR: begin
          sh  <= {sh[DW-2:0], mdio_i};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_ADDR) begin
            cnt     <= '0;
            match_q <= match_w;
            reg_q   <= rd_addr;
            state   <= ST_TURN;
            if (is_rd) sh <= rd_data;
          end
        end
        ST_TURN: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            if (is_rd && match_q) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end
          end else begin
            cnt   <= '0;
            state <= ST_DATA;
            if (is_rd) begin
              mdio_o <= sh[DW-1];
              sh     <= sh << 1;
            end
          end
        end
        ST_DATA: begin
          cnt <= cnt + 1'b1;
          if (is_rd) begin
            mdio_o <= sh[DW-1];
            sh     <= sh << 1;
          end else begin
            sh <= {sh[DW-2:0], mdio_i};
          end
          if (cnt == LAST_DATA) begin
            cnt      <= '0;
            state    <= ST_HUNT;
            seen_one <= 1'b0;
            mdio_oe  <= 1'b0;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (state == ST_HUNT && !mdio_oe)); // R4
  AST_TA1_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN && cnt == '0) |-> !mdio_oe); // R5
  AST_TA2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TURN && cnt != '0 && is_rd && match_q) |-> (mdio_oe && !mdio_o)); // R5
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |-> !mdio_oe); // R7
  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !match_q) |-> !mdio_oe); // R8
  AST_HUNT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> !mdio_oe); // R9
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  parameter int PAW  = 5,
  parameter int SW   = 3
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic [SW-1:0] strap_i,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int RAW = $clog2(NREG);

  logic [SW-1:0]  strap_q;
  logic [RAW-1:0] rd_addr, wr_addr;
  logic [DW-1:0]  rd_data, wr_data;
  logic           wr_en;

  // Transparent while reset is low, frozen once it rises.
  always_latch begin
    if (!rst_n) strap_q <= strap_i;
  end

  mdio_frame_fsm #(.DW(DW), .RAW(RAW), .PAW(PAW), .SW(SW)) u_fsm (
    .clk     (mdc),
    .rst_n   (rst_n),
    .strap   (strap_q),
    .mdio_i  (mdio_i),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk   (mdc),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  logic          chk_live;
  logic [SW-1:0] chk_strap;
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) chk_live <= 1'b0;
    else        chk_live <= 1'b1;
  end
  always_ff @(posedge mdc) chk_strap <= strap_q;

  AST_STRAP_HELD: assert property (@(posedge mdc) disable iff (!rst_n)
    chk_live |-> (strap_q == chk_strap)); // R3
endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } exp_t;

  logic       mdc = 1'b0, clk_run = 1'b0, rst_n = 1'b0;
  logic [2:0] strap_i = 3'd5;
  logic [2:0] strap_ref = 3'd5;
  logic       m_oe = 1'b0, m_o = 1'b1;
  logic       i_o, i_oe, line;
  logic [15:0] exp_regs [32];
  exp_t       expq [$];
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  assign line = i_oe ? i_o : (m_oe ? m_o : 1'b1);

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .mdc(mdc), .rst_n(rst_n), .strap_i(strap_i),
    .mdio_i(line), .mdio_o(i_o), .mdio_oe(i_oe)
  );

  always begin
    #(CLK_PERIOD/2);
    if (clk_run || mdc) mdc = ~mdc;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic b);
    @(negedge mdc); m_oe = 1'b1; m_o = b;
  endtask

  task automatic rel();
    @(negedge mdc); m_oe = 1'b0;
  endtask

  // One frame as the station sends it; the scoreboard gets what the slave must return.
  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input bit silent, input string tag);
    bit hit;
    exp_t e;
    hit = (phy[4:3] == 2'b00) && (phy[2:0] == strap_ref) && !silent;
    drv(1'b0); drv(1'b1);
    for (int i = 1; i >= 0; i--) drv(op[i]);
    for (int i = 4; i >= 0; i--) drv(phy[i]);
    for (int i = 4; i >= 0; i--) drv(ra[i]);
    if (op == 2'b10) begin
      rel(); #1;
      check(!i_oe, {tag, " R5 first turnaround undriven"}, i_oe, 0);
      if (hit) begin
        e.v = exp_regs[ra]; e.tag = tag;
        expq.push_back(e);
      end
      repeat (17) rel();
    end else if (op == 2'b01) begin
      drv(1'b1); drv(1'b0);
      for (int i = 15; i >= 0; i--) drv(wd[i]);
      if (hit) exp_regs[ra] = wd;
    end else begin
      repeat (18) rel();
    end
    rel(); rel();
  endtask

  // Monitor: gathers every response the slave drives and pops the scoreboard.
  logic        mon_act = 1'b0;
  int          mon_n = 0;
  logic [15:0] mon_v = '0;
  always @(negedge mdc) begin
    exp_t e;
    #1;
    if (i_oe) begin
      check(!m_oe, "R7 no contention with station", m_oe, 0);
      if (!mon_act) begin
        mon_act = 1'b1; mon_n = 0;
        check(i_o == 1'b0, "R5 second turnaround driven low", i_o, 0);
      end else begin
        mon_v = {mon_v[14:0], i_o};
        mon_n++;
      end
    end else if (mon_act) begin
      mon_act = 1'b0;
      if (expq.size() == 0) begin
        check(0, "R8 R2 R4 R9 unexpected response", mon_v, 0);
      end else begin
        e = expq.pop_front();
        check(mon_n == 16, {e.tag, " R6 data bit count"}, mon_n, 16);
        check(mon_v == e.v, {e.tag, " R1 R6 read value"}, mon_v, e.v);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_regs[i] = 16'h0000;
    #(CLK_PERIOD * 2);
    check(!i_oe, "R4 output enable low in reset", i_oe, 0);
    rst_n = 1'b1;
    #(CLK_PERIOD / 2);
    strap_i = 3'd2;                 // R3: must not move the latched address
    m_oe = 1'b1; m_o = 1'b1;        // first post-reset bit is an idle 1 that must be ignored
    clk_run = 1'b1;
    frame(2'b10, 5'd5, 5'd0, 16'h0, 1'b1, "R4");
    rel(); rel();
    frame(2'b10, 5'd5, 5'd7, 16'h0, 1'b0, "R10");
    frame(2'b10, 5'd2, 5'd0, 16'h0, 1'b0, "R3");
    frame(2'b01, 5'd5, 5'd0, 16'hA5C3, 1'b0, "R7");
    frame(2'b10, 5'd5, 5'd0, 16'h0, 1'b0, "R7");
    frame(2'b01, 5'd5, 5'd31, 16'h8001, 1'b0, "R7");
    frame(2'b01, 5'd5, 5'd17, 16'hFFFF, 1'b0, "R7");
    frame(2'b10, 5'd5, 5'd31, 16'h0, 1'b0, "R10");
    frame(2'b10, 5'd5, 5'd17, 16'h0, 1'b0, "R10");
    frame(2'b10, 5'd5, 5'd1, 16'h0, 1'b0, "R10");
    frame(2'b01, 5'd13, 5'd0, 16'h1234, 1'b0, "R2");
    frame(2'b10, 5'd13, 5'd0, 16'h0, 1'b0, "R2");
    frame(2'b01, 5'd4, 5'd17, 16'h0000, 1'b0, "R8");
    frame(2'b10, 5'd5, 5'd0, 16'h0, 1'b0, "R8");
    frame(2'b10, 5'd5, 5'd17, 16'h0, 1'b0, "R8");
    frame(2'b11, 5'd5, 5'd0, 16'h0, 1'b0, "R9");
    frame(2'b00, 5'd5, 5'd0, 16'h0, 1'b0, "R9");
    frame(2'b10, 5'd5, 5'd31, 16'h0, 1'b0, "R9");
    @(negedge mdc); clk_run = 1'b0;
    #(CLK_PERIOD * 20);
    clk_run = 1'b1;
    frame(2'b01, 5'd5, 5'd3, 16'h0F0F, 1'b0, "R11");
    frame(2'b10, 5'd5, 5'd3, 16'h0, 1'b0, "R11");
    frame(2'b01, 5'd5, 5'd0, 16'h5555, 1'b0, "R1");
    frame(2'b10, 5'd5, 5'd0, 16'h0, 1'b0, "R1");
    frame(2'b10, 5'd5, 5'd31, 16'h0, 1'b0, "R10");
    repeat (4) rel();
    check(expq.size() == 0, "R6 every served read answered", expq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule